// File: doc/BRIEF.md
# Selectable Reset Source Generator

This block produces a reset pulse for the rest of a chip. A two-bit source select field decides what may trigger the pulse. One setting arms nothing. A second setting arms two external sources: a rising edge on the awake input, which counts only while the device runs in terminal mode, and any change of the command/indication code. A third setting arms a watchdog that software must service.

Software services the watchdog by writing a two-step pattern to the service bits. A watchdog expiry gives a short pulse, and the external sources give a longer one. Both widths, and the watchdog period, are parameters counted in clock cycles. Software cannot disarm the watchdog once it has been selected. Only the hardware reset input clears it.

When a pulse ends, a sticky status flag for the source that caused it is set, and the interrupt line goes high. A status read strobe clears the flags. The register write port is a plain strobe and accepts a write in every cycle, so it never exerts back-pressure. None of the block's ports carries a stream.

Top module: `rst_src_gen`

## Requirements
- R1: While the select field holds 00 or 01, neither awake edges nor code changes produce a reset pulse or set any status flag.
- R2: With select 10, a change of `ci_code` in a cycle drives `rst_pulse_o` high from the next clock edge for exactly EXT_PULSE cycles.
- R3: With select 10, a rising edge of `awake_in` gives an EXT_PULSE-cycle pulse only when `term_mode` is 1. With `term_mode` 0 the edge has no effect.
- R4: Writing select 11 clears and starts the watchdog. With no service, `rst_pulse_o` rises WD_PERIOD clock edges after the arming write and stays high for WD_PULSE cycles.
- R5: A service write with `cfg_svc`=01 followed directly by a service write with `cfg_svc`=10 restarts the watchdog period from the second write. The two writes in the reverse order do not restart it.
- R6: Once the select field is 11, later writes cannot change it, and the watchdog keeps running. Only `rst_n` returns it to 00.
- R7: In the cycle `rst_pulse_o` falls, `stat_flags` gains the bit of the pulse's source (bit0 watchdog, bit1 code change, bit2 awake) and `irq_o` is high. `irq_o` is high whenever any flag is set.
- R8: A cycle with `stat_rd` high clears `stat_flags` and `irq_o` from the next edge.
- R9: A trigger that arrives while a pulse is active neither lengthens that pulse nor adds a flag.
- R10: After reset, `rst_pulse_o` and `irq_o` are low, `stat_flags` is 000 and `sel_state` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Source select value written |
| cfg_svc | input | 2 | Watchdog service bits written (bit0 first bit, bit1 second bit) |
| term_mode | input | 1 | High when the device operates in terminal mode |
| awake_in | input | 1 | Subscriber awake request |
| ci_code | input | CODE_W | Command/indication code |
| stat_rd | input | 1 | Status read strobe, clears flags |
| rst_pulse_o | output | 1 | Generated reset pulse, active high |
| irq_o | output | 1 | Interrupt, high while any flag is set |
| stat_flags | output | 3 | Sticky source flags |
| sel_state | output | 2 | Current source select value |

## Verification
The bound checker checks these rules on every cycle:
- The select field stays locked once the watchdog is chosen.
- An unarmed select value cannot start a pulse.
- Every falling pulse edge finds the interrupt high.
- A read strobe outside a pulse leaves the flags empty.
- No pulse is a single cycle long.

Other properties depend on counting cycles over a whole scenario, so only the bench's scenarios can show them:
- the exact start cycle and width of each pulse family;
- the service pattern and its wrong order;
- that terminal mode gates the awake input;
- that a trigger arriving mid-pulse is ignored.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_WDOG  = 2'd1,
    SRC_CODE  = 2'd2,
    SRC_AWAKE = 2'd3
  } src_e;

  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b10;
  localparam logic [1:0] SEL_WDOG = 2'b11;

  localparam logic [1:0] SVC_STEP1 = 2'b01;
  localparam logic [1:0] SVC_STEP2 = 2'b10;

  localparam int FLAG_W     = 3;
  localparam int FLAG_WDOG  = 0;
  localparam int FLAG_CODE  = 1;
  localparam int FLAG_AWAKE = 2;

endpackage

// File: rtl/rsg_wdog.sv
module rsg_wdog
  import rst_src_pkg::*;
#(
  parameter int PERIOD = 128000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_start,
  input  logic       armed,
  input  logic       wr_en,
  input  logic [1:0] svc,
  output logic       expire
);

  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  typedef enum logic {SEQ_IDLE, SEQ_HALF} seq_e;

  logic [CW-1:0] cnt_q;
  seq_e          seq_q;
  logic          svc_done;

  assign svc_done = armed && wr_en && (seq_q == SEQ_HALF) && (svc == SVC_STEP2);
  assign expire   = armed && !svc_done && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seq_q <= SEQ_IDLE;
    end else if (arm_start) begin
      cnt_q <= '0;
      seq_q <= SEQ_IDLE;
    end else if (armed) begin
      if (svc_done || (cnt_q == LAST)) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
      if (wr_en) seq_q <= (svc == SVC_STEP1) ? SEQ_HALF : SEQ_IDLE;
    end
  end

endmodule

// File: rtl/rsg_edge_det.sv
module rsg_edge_det #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              awake_in,
  input  logic              term_mode,
  output logic              code_chg,
  output logic              awake_rise
);

  logic              primed_q;
  logic [CODE_W-1:0] code_q;
  logic              awake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      code_q   <= '0;
      awake_q  <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      code_q   <= code_in;
      awake_q  <= awake_in;
    end
  end

  assign code_chg   = primed_q && (code_in != code_q);
  assign awake_rise = primed_q && term_mode && awake_in && !awake_q;

endmodule

// File: rtl/rsg_pulse.sv
module rsg_pulse
  import rst_src_pkg::*;
#(
  parameter int WD_PULSE  = 125,
  parameter int EXT_PULSE = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e trig,
  output logic active,
  output src_e done_src
);

  localparam int MAXW = (WD_PULSE > EXT_PULSE) ? WD_PULSE : EXT_PULSE;
  localparam int PW   = $clog2(MAXW + 1);

  logic [PW-1:0] pcnt_q;
  src_e          cur_q;
  logic          active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pcnt_q   <= '0;
      cur_q    <= SRC_NONE;
    end else if (!active_q) begin
      if (trig != SRC_NONE) begin
        active_q <= 1'b1;
        cur_q    <= trig;
        pcnt_q   <= (trig == SRC_WDOG) ? PW'(WD_PULSE - 1) : PW'(EXT_PULSE - 1);
      end
    end else if (pcnt_q == '0) begin
      active_q <= 1'b0;
    end else begin
      pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign active   = active_q;
  assign done_src = (active_q && (pcnt_q == '0)) ? cur_q : SRC_NONE;

endmodule

// File: rtl/rst_src_gen.sv
module rst_src_gen
  import rst_src_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int WD_PERIOD = 128000,
  parameter int WD_PULSE  = 125,
  parameter int EXT_PULSE = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [1:0]        cfg_svc,
  input  logic              term_mode,
  input  logic              awake_in,
  input  logic [CODE_W-1:0] ci_code,
  input  logic              stat_rd,
  output logic              rst_pulse_o,
  output logic              irq_o,
  output logic [2:0]        stat_flags,
  output logic [1:0]        sel_state
);

  logic [1:0]        sel_q;
  logic              locked;
  logic              arm_start;
  logic              wd_expire;
  logic              code_chg;
  logic              awake_rise;
  src_e              trig;
  src_e              done_src;
  logic              pulse_active;
  logic [FLAG_W-1:0] set_mask;
  logic [FLAG_W-1:0] flags_q;

  assign locked    = (sel_q == SEL_WDOG);
  assign arm_start = cfg_wr_en && !locked && (cfg_sel == SEL_WDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sel_q <= SEL_OFF;
    else if (cfg_wr_en && !locked) sel_q <= cfg_sel;
  end

  rsg_wdog #(.PERIOD(WD_PERIOD)) wdog_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_start (arm_start),
    .armed     (locked),
    .wr_en     (cfg_wr_en),
    .svc       (cfg_svc),
    .expire    (wd_expire)
  );

  rsg_edge_det #(.CODE_W(CODE_W)) det_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_in    (ci_code),
    .awake_in   (awake_in),
    .term_mode  (term_mode),
    .code_chg   (code_chg),
    .awake_rise (awake_rise)
  );

  always_comb begin
    trig = SRC_NONE;
    if (locked) begin
      if (wd_expire) trig = SRC_WDOG;
    end else if (sel_q == SEL_EXT) begin
      if (code_chg)        trig = SRC_CODE;
      else if (awake_rise) trig = SRC_AWAKE;
    end
  end

  rsg_pulse #(.WD_PULSE(WD_PULSE), .EXT_PULSE(EXT_PULSE)) pulse_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .active   (pulse_active),
    .done_src (done_src)
  );

  always_comb begin
    set_mask = '0;
    case (done_src)
      SRC_WDOG:  set_mask[FLAG_WDOG]  = 1'b1;
      SRC_CODE:  set_mask[FLAG_CODE]  = 1'b1;
      SRC_AWAKE: set_mask[FLAG_AWAKE] = 1'b1;
      default:   set_mask = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (stat_rd ? '0 : flags_q) | set_mask;
  end

  assign rst_pulse_o = pulse_active;
  assign stat_flags  = flags_q;
  assign irq_o       = |flags_q;
  assign sel_state   = sel_q;

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       rst_pulse_o,
  input logic       irq_o,
  input logic [2:0] stat_flags,
  input logic [1:0] sel_state
);

  assert_sel_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state == 2'b11) |=> (sel_state == 2'b11));

  assert_unarmed_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_state[1] == 1'b0 && !rst_pulse_o) |=> !rst_pulse_o);

  assert_irq_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pulse_o) |-> irq_o);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rst_pulse_o) |=> (stat_flags == 3'b000));

  assert_no_short_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |=> rst_pulse_o);

endmodule

bind rst_src_gen rsg_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_rd     (stat_rd),
  .rst_pulse_o (rst_pulse_o),
  .irq_o       (irq_o),
  .stat_flags  (stat_flags),
  .sel_state   (sel_state)
);

// File: tb/rst_src_gen_tb_top.sv
`timescale 1ns/1ps
module rst_src_gen_tb_top;

  localparam int CODE_W    = 4;
  localparam int WD_PERIOD = 64;
  localparam int WD_PULSE  = 6;
  localparam int EXT_PULSE = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [1:0]        cfg_sel = '0;
  logic [1:0]        cfg_svc = '0;
  logic              term_mode = 1'b0;
  logic              awake_in = 1'b0;
  logic [CODE_W-1:0] ci_code = '0;
  logic              stat_rd = 1'b0;
  logic              rst_pulse_o;
  logic              irq_o;
  logic [2:0]        stat_flags;
  logic [1:0]        sel_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_src_gen #(
    .CODE_W(CODE_W), .WD_PERIOD(WD_PERIOD),
    .WD_PULSE(WD_PULSE), .EXT_PULSE(EXT_PULSE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_svc(cfg_svc), .term_mode(term_mode), .awake_in(awake_in),
    .ci_code(ci_code), .stat_rd(stat_rd), .rst_pulse_o(rst_pulse_o),
    .irq_o(irq_o), .stat_flags(stat_flags), .sel_state(sel_state)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic       ev_code;
    logic       ev_awake;
    logic       term;
    logic [7:0] exp_start;
    logic [7:0] exp_width;
    logic [2:0] exp_flags;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 3'b000},
    '{2'b00, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 3'b000},
    '{2'b01, 1'b1, 1'b1, 1'b1, 8'd0, 8'd0, 3'b000},
    '{2'b10, 1'b1, 1'b0, 1'b0, 8'd1, 8'(EXT_PULSE), 3'b010},
    '{2'b10, 1'b0, 1'b1, 1'b1, 8'd1, 8'(EXT_PULSE), 3'b100},
    '{2'b10, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0, 3'b000},
    '{2'b10, 1'b1, 1'b1, 1'b1, 8'd1, 8'(EXT_PULSE), 3'b010}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_sel = '0; cfg_svc = '0;
    awake_in = 1'b0; ci_code = '0; stat_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] s, input logic [1:0] v);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_svc = v;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_svc = '0;
  endtask

  task automatic measure(input int limit, input int inject_at,
                         output int start, output int width);
    start = 0; width = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (i == inject_at) begin
        ci_code = ci_code ^ 4'h2;
        awake_in = 1'b1;
      end
      if (rst_pulse_o) begin
        if (start == 0) start = i;
        width++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int st, wd;
    hw_reset();
    // R10: reset state
    chk("R10 pulse", int'(rst_pulse_o), 0);
    chk("R10 irq", int'(irq_o), 0);
    chk("R10 flags", int'(stat_flags), 0);
    chk("R10 sel", int'(sel_state), 0);

    // table: R1 (sel 00/01), R2 code, R3 awake and term gating
    for (int v = 0; v < NVEC; v++) begin
      hw_reset();
      term_mode = VECS[v].term;
      do_write(VECS[v].sel, 2'b00);
      if (VECS[v].ev_code)  ci_code = ci_code ^ 4'h1;
      if (VECS[v].ev_awake) awake_in = 1'b1;
      measure(EXT_PULSE + 8, 0, st, wd);
      chk($sformatf("R1/R2/R3 vec%0d start", v), st, int'(VECS[v].exp_start));
      chk($sformatf("R1/R2/R3 vec%0d width", v), wd, int'(VECS[v].exp_width));
      chk($sformatf("R7 vec%0d flags", v), int'(stat_flags), int'(VECS[v].exp_flags));
      chk($sformatf("R7 vec%0d irq", v), int'(irq_o), int'(VECS[v].exp_flags != 3'b000));
    end

    // R8: read strobe clears flags
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R8 flags cleared", int'(stat_flags), 0);
    chk("R8 irq cleared", int'(irq_o), 0);

    // R9: second trigger mid-pulse neither extends nor adds flag
    hw_reset();
    term_mode = 1'b1;
    do_write(2'b10, 2'b00);
    ci_code = ci_code ^ 4'h1;
    measure(EXT_PULSE + 8, 4, st, wd);
    chk("R9 start", st, 1);
    chk("R9 width", wd, EXT_PULSE);
    chk("R9 flags", int'(stat_flags), 3'b010);

    // R4: unserviced watchdog expires
    hw_reset();
    do_write(2'b11, 2'b00);
    chk("R6 sel armed", int'(sel_state), 3);
    measure(WD_PERIOD + WD_PULSE + 4, 0, st, wd);
    chk("R4 start", st, WD_PERIOD);
    chk("R4 width", wd, WD_PULSE);
    chk("R7 wdog flag", int'(stat_flags), 3'b001);

    // R5: correct service pair restarts the period
    hw_reset();
    do_write(2'b11, 2'b00);
    repeat (20) @(negedge clk);
    do_write(2'b11, 2'b01);
    do_write(2'b11, 2'b10);
    measure(WD_PERIOD + WD_PULSE + 4, 0, st, wd);
    chk("R5 serviced start", st, WD_PERIOD);

    // R5: reversed order does not service
    hw_reset();
    do_write(2'b11, 2'b00);
    repeat (20) @(negedge clk);
    do_write(2'b11, 2'b10);
    do_write(2'b11, 2'b01);
    measure(WD_PERIOD + WD_PULSE + 4, 0, st, wd);
    chk("R5 reversed start", st, WD_PERIOD - 22);

    // R6: select locked, watchdog keeps running
    hw_reset();
    do_write(2'b11, 2'b00);
    do_write(2'b00, 2'b00);
    chk("R6 sel stays", int'(sel_state), 3);
    measure(WD_PERIOD + WD_PULSE + 4, 0, st, wd);
    chk("R6 still expires", st, WD_PERIOD - 1);
    hw_reset();
    chk("R6 hw reset clears", int'(sel_state), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule